// File: doc/BRIEF.md
# I2C Controller Status Flags

This block keeps the three status flags of an I2C controller that can act as master or as slave. The first is an active-low pending flag that drops when a byte has been handled. The second is a bus-busy flag. The third is a transfer-direction flag. The block updates them from single-cycle event strobes sent by the byte engine: byte done, address matched, arbitration lost, START seen, STOP seen and ACK missing. It also takes a software write to the data shift register, software writes to the busy and direction flags, a START request, and the enable, master and address-less control bits.

From the flags it derives three signals. The interrupt request is a one-cycle pulse marking the cycle in which the pending flag first reads low. The SCL hold request stays active for as long as the pending flag is low. The START grant goes high only while the bus is idle. A START request made while the bus is busy is refused, and the refusal drops the direction flag back to receive. When a set and a clear for the same flag arrive in the same cycle, the clear takes effect. A low enable bit forces every flag to its idle value.

Top module: `i2c_status_flags`

## Requirements
- R1: After reset, and one cycle after any cycle with `en`=0, `pin_n`=1, `busy`=0 and `xmit`=0.
- R2: With `en`=1, `ev_byte_done` or `ev_arb_lost` makes `pin_n` 0 on the next cycle. A `dsr_write` with no clearing event in the same cycle makes it 1. A clear wins over `dsr_write`.
- R3: With `en`=1, `master`=0 and `xmit`=0 (slave receive), `ev_addr_match` makes `pin_n` 0 whatever `addrless` is. With `master`=1, `ev_addr_match` has no effect on `pin_n`.
- R4: `irq` is 1 for exactly the one cycle in which `pin_n` first reads 0 after reading 1.
- R5: `scl_hold` equals the inverse of `pin_n` in every cycle.
- R6: With `en`=1, `ev_start` sets `busy` and `ev_stop` clears it on the next cycle. `ev_stop` wins over `ev_start`.
- R7: `busy_wr` loads `busy_wdata` into `busy` only when `master`=1 and `xmit`=1 and neither `ev_start` nor `ev_stop` is present. In any other mode the write is ignored.
- R8: `start_grant` = `start_req` & `en` & ~`busy`. A `start_req` while `busy`=1 clears `xmit` on the next cycle.
- R9: In slave receive with `addrless`=0, `ev_addr_match` loads `rw_bit` into `xmit` (1 = transmit). With `addrless`=1 it leaves `xmit` unchanged.
- R10: With `en`=1, `xmit` clears on the next cycle after `ev_arb_lost`, `ev_stop`, `ev_start` with `master`=0, or `ev_nack` with `master`=0. `ev_nack` with `master`=1 keeps `xmit`.
- R11: `xmit_wr` loads `xmit_wdata` when no clear or address load is present in the same cycle. A clear wins over the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Interface enable; 0 forces idle flags |
| master | input | 1 | 1 = master mode |
| addrless | input | 1 | 1 = address-less slave mode |
| ev_byte_done | input | 1 | Byte (with ACK clock) finished |
| ev_addr_match | input | 1 | Address byte received and matched |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_start | input | 1 | START detected on the bus |
| ev_stop | input | 1 | STOP detected on the bus |
| ev_nack | input | 1 | ACK not returned |
| rw_bit | input | 1 | R/W bit of the received address |
| dsr_write | input | 1 | Software write to the data shift register |
| busy_wr | input | 1 | Software write strobe for busy |
| busy_wdata | input | 1 | Value for a software busy write |
| xmit_wr | input | 1 | Software write strobe for direction |
| xmit_wdata | input | 1 | Value for a software direction write |
| start_req | input | 1 | Request to generate a START |
| pin_n | output | 1 | Pending flag, 0 = byte awaiting service |
| busy | output | 1 | Bus-busy flag |
| xmit | output | 1 | Direction flag, 1 = transmit |
| irq | output | 1 | One-cycle interrupt request |
| scl_hold | output | 1 | Request to hold SCL low |
| start_grant | output | 1 | START request accepted |

## Verification
On every cycle, the assertions check several relations: each clearing event pulls its flag to 0 one cycle later, a low enable leaves all flags idle, the interrupt never lasts two cycles, and a refused START always clears the direction flag. Some behaviour is visible only in the bench's scenarios: the order of priority among a simultaneous clear, load and software write, the mode gating of the busy write, and the address-less case leaving the direction flag alone. The bench covers these with a reference model under random and directed stimulus.

// File: rtl/i2c_flag_pkg.sv
package i2c_flag_pkg;
   localparam int unsigned NUM_EVENTS = 6;

   typedef struct packed {
      logic byte_done;
      logic addr_match;
      logic arb_lost;
      logic start;
      logic stop;
      logic nack;
   } evt_t;

   function automatic logic next_with_priority(input logic cur, input logic clr,
                                               input logic set);
      if (clr) return 1'b0;
      if (set) return 1'b1;
      return cur;
   endfunction
endpackage

// File: rtl/i2c_pin_flag.sv
module i2c_pin_flag #(
   parameter int unsigned SYNC_IRQ = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic clr_ev,
   input  logic set_ev,
   output logic pin_n,
   output logic irq
);
   import i2c_flag_pkg::*;

   logic pin_q, pin_d, pin_dly;

   always_comb begin
      if (!en) pin_d = 1'b1;
      else     pin_d = next_with_priority(pin_q, clr_ev, set_ev);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q   <= 1'b1;
         pin_dly <= 1'b1;
      end else begin
         pin_q   <= pin_d;
         pin_dly <= pin_q;
      end
   end

   generate
      if (SYNC_IRQ > 1) begin : g_bad
         $error("SYNC_IRQ must be 0 or 1");
      end else if (SYNC_IRQ == 1) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= pin_dly & ~pin_q;
         end
         assign irq = irq_q;
      end else begin : g_comb
         assign irq = pin_dly & ~pin_q;
      end
   endgenerate

   assign pin_n = pin_q;

   assert_pin_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && clr_ev) |=> !pin_n);
   assert_pin_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> pin_n);
   assert_irq_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
endmodule

// File: rtl/i2c_busy_flag.sv
module i2c_busy_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic start_ev,
   input  logic stop_ev,
   input  logic wr_allowed,
   input  logic wr,
   input  logic wdata,
   output logic busy
);
   logic busy_q, busy_d;

   always_comb begin
      busy_d = busy_q;
      if (!en)                   busy_d = 1'b0;
      else if (stop_ev)          busy_d = 1'b0;
      else if (start_ev)         busy_d = 1'b1;
      else if (wr && wr_allowed) busy_d = wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_q <= 1'b0;
      else        busy_q <= busy_d;
   end

   assign busy = busy_q;

   assert_stop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && stop_ev) |=> !busy);
   assert_busy_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !busy);
   assert_sw_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !wr_allowed && !start_ev && !stop_ev) |=> $stable(busy));
endmodule

// File: rtl/i2c_dir_flag.sv
module i2c_dir_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic clr_ev,
   input  logic load_ev,
   input  logic load_val,
   input  logic wr,
   input  logic wdata,
   output logic xmit
);
   logic x_q, x_d;

   always_comb begin
      x_d = x_q;
      if (!en)          x_d = 1'b0;
      else if (clr_ev)  x_d = 1'b0;
      else if (load_ev) x_d = load_val;
      else if (wr)      x_d = wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) x_q <= 1'b0;
      else        x_q <= x_d;
   end

   assign xmit = x_q;

   assert_dir_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (en && clr_ev) |=> !xmit);
   assert_dir_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr_ev && load_ev) |=> (xmit == $past(load_val)));
endmodule

// File: rtl/i2c_status_flags.sv
module i2c_status_flags #(
   parameter int unsigned SYNC_IRQ = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic master,
   input  logic addrless,
   input  logic ev_byte_done,
   input  logic ev_addr_match,
   input  logic ev_arb_lost,
   input  logic ev_start,
   input  logic ev_stop,
   input  logic ev_nack,
   input  logic rw_bit,
   input  logic dsr_write,
   input  logic busy_wr,
   input  logic busy_wdata,
   input  logic xmit_wr,
   input  logic xmit_wdata,
   input  logic start_req,
   output logic pin_n,
   output logic busy,
   output logic xmit,
   output logic irq,
   output logic scl_hold,
   output logic start_grant
);
   import i2c_flag_pkg::*;

   evt_t ev;
   logic slave_rx, pin_clr, dir_clr, dir_load, start_blocked;

   assign ev = '{byte_done: ev_byte_done, addr_match: ev_addr_match,
                 arb_lost: ev_arb_lost, start: ev_start, stop: ev_stop,
                 nack: ev_nack};

   assign slave_rx      = !master && !xmit;
   assign start_blocked = start_req && busy;
   assign pin_clr       = ev.byte_done | ev.arb_lost | (ev.addr_match & slave_rx);
   assign dir_clr       = ev.arb_lost | ev.stop | start_blocked |
                          ((ev.start | ev.nack) & !master);
   assign dir_load      = ev.addr_match & slave_rx & !addrless;

   i2c_pin_flag #(.SYNC_IRQ(SYNC_IRQ)) u_pin (
      .clk(clk), .rst_n(rst_n), .en(en), .clr_ev(pin_clr),
      .set_ev(dsr_write), .pin_n(pin_n), .irq(irq));

   i2c_busy_flag u_busy (
      .clk(clk), .rst_n(rst_n), .en(en), .start_ev(ev.start),
      .stop_ev(ev.stop), .wr_allowed(master && xmit), .wr(busy_wr),
      .wdata(busy_wdata), .busy(busy));

   i2c_dir_flag u_dir (
      .clk(clk), .rst_n(rst_n), .en(en), .clr_ev(dir_clr),
      .load_ev(dir_load), .load_val(rw_bit), .wr(xmit_wr),
      .wdata(xmit_wdata), .xmit(xmit));

   assign scl_hold    = ~pin_n;
   assign start_grant = start_req & en & ~busy;

   assert_blocked_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && start_req && busy) |=> !xmit);
   assert_hold_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
      scl_hold != pin_n);
   assert_addr_pin_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && ev_addr_match && !master && !xmit) |=> !pin_n);
endmodule

// File: tb/sim_i2c_status_flags.sv
module sim_i2c_status_flags;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic en, master, addrless, bd, am, al, st, sp, nk, rw, dw, bw, bwd, tw, twd, sr;
   logic pin_n, busy, xmit, irq, scl_hold, start_grant;
   logic m_pin, m_bb, m_trx, m_pdly;
   int   n_chk = 0, n_fail = 0;
   bit   done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_status_flags u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .master(master), .addrless(addrless),
      .ev_byte_done(bd), .ev_addr_match(am), .ev_arb_lost(al), .ev_start(st),
      .ev_stop(sp), .ev_nack(nk), .rw_bit(rw), .dsr_write(dw), .busy_wr(bw),
      .busy_wdata(bwd), .xmit_wr(tw), .xmit_wdata(twd), .start_req(sr),
      .pin_n(pin_n), .busy(busy), .xmit(xmit), .irq(irq), .scl_hold(scl_hold),
      .start_grant(start_grant));

   function automatic logic nxt_pin();
      if (!en) return 1'b1;
      if (bd || al || (am && !master && !m_trx)) return 1'b0;
      if (dw) return 1'b1;
      return m_pin;
   endfunction

   function automatic logic nxt_bb();
      if (!en || sp) return 1'b0;
      if (st) return 1'b1;
      if (bw && master && m_trx) return bwd;
      return m_bb;
   endfunction

   function automatic logic nxt_trx();
      if (!en) return 1'b0;
      if (al || sp || (sr && m_bb) || ((st || nk) && !master)) return 1'b0;
      if (am && !master && !m_trx && !addrless) return rw;
      if (tw) return twd;
      return m_trx;
   endfunction

   task automatic chk(input logic act, input logic exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b at %0t", what, act, exp, $time);
      end
   endtask

   task automatic check_all(input string tag);
      chk(pin_n, m_pin, {tag, " pin_n R2"});
      chk(busy, m_bb, {tag, " busy R6"});
      chk(xmit, m_trx, {tag, " xmit R10"});
      chk(irq, m_pdly & ~m_pin, {tag, " irq R4"});
      chk(scl_hold, ~m_pin, {tag, " scl_hold R5"});
      chk(start_grant, sr & en & ~m_bb, {tag, " start_grant R8"});
   endtask

   task automatic idle_in();
      {bd, am, al, st, sp, nk, rw, dw, bw, bwd, tw, twd, sr} = '0;
   endtask

   // inputs already set after a negedge; advance one clock and check
   task automatic step(input string tag);
      logic np, nb, nt;
      #1 check_all(tag);
      np = nxt_pin(); nb = nxt_bb(); nt = nxt_trx();
      @(posedge clk);
      m_pdly = m_pin; m_pin = np; m_bb = nb; m_trx = nt;
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int unsigned r;
      r = $urandom(32'd1357);
      en = 1'b1; master = 1'b0; addrless = 1'b0; idle_in();
      m_pin = 1'b1; m_bb = 1'b0; m_trx = 1'b0; m_pdly = 1'b1;
      @(negedge clk); @(negedge clk);
      #1 chk(pin_n, 1'b1, "R1 reset pin_n"); chk(busy, 1'b0, "R1 reset busy");
      chk(xmit, 1'b0, "R1 reset xmit");
      rst_n = 1'b1;
      @(negedge clk);

      // R9: slave address with read bit loads transmit, pin drops (R3)
      am = 1; rw = 1; step("R9 load");
      idle_in(); step("R3 addr pin");
      chk(xmit, 1'b1, "R9 xmit after read address");
      chk(pin_n, 1'b0, "R3 pin after address");
      // R2: data write releases pin, then byte done with write drops it
      dw = 1; step("R2 set"); idle_in(); step("R2");
      bd = 1; dw = 1; step("R2 clr wins"); idle_in(); step("R2");
      chk(pin_n, 1'b0, "R2 clear beats write");
      // R10: nack as slave clears
      nk = 1; step("R10 nack"); idle_in(); step("R10");
      chk(xmit, 1'b0, "R10 nack clears slave xmit");
      // R9: address-less keeps xmit
      dw = 1; step("R9"); addrless = 1; idle_in(); am = 1; rw = 1; step("R9 als");
      idle_in(); step("R9"); chk(xmit, 1'b0, "R9 addrless keeps xmit");
      addrless = 0;
      // R7: busy write ignored as slave
      bw = 1; bwd = 1; step("R7 slave"); idle_in(); step("R7");
      chk(busy, 1'b0, "R7 write ignored in slave");
      // R11: master sets transmit, then busy write allowed
      master = 1; tw = 1; twd = 1; step("R11"); idle_in(); step("R11");
      chk(xmit, 1'b1, "R11 xmit write");
      bw = 1; bwd = 1; step("R7 mtx"); idle_in(); step("R7");
      chk(busy, 1'b1, "R7 write in master transmit");
      // R3: addr_match as master no effect
      dw = 1; step("R3"); idle_in(); am = 1; step("R3 master"); idle_in(); step("R3");
      chk(pin_n, 1'b1, "R3 master addr ignored");
      // R10: nack as master keeps
      nk = 1; step("R10 mnack"); idle_in(); step("R10");
      chk(xmit, 1'b1, "R10 master nack keeps");
      // R8: blocked start clears xmit
      sr = 1; step("R8 blocked"); idle_in(); step("R8");
      chk(xmit, 1'b0, "R8 blocked start clears xmit");
      // R11: clear wins over write
      tw = 1; twd = 1; al = 1; step("R11 clr"); idle_in(); step("R11");
      chk(xmit, 1'b0, "R11 clear beats write");
      // R6: stop beats start
      st = 1; sp = 1; step("R6 both"); idle_in(); step("R6");
      chk(busy, 1'b0, "R6 stop beats start");
      st = 1; step("R6 start"); idle_in(); step("R6");
      chk(busy, 1'b1, "R6 start sets");
      // R1: disable
      en = 0; step("R1 off"); step("R1 off");
      chk(busy, 1'b0, "R1 disabled busy"); chk(pin_n, 1'b1, "R1 disabled pin");
      en = 1; master = 0;

      for (int i = 0; i < 3000; i++) begin
         r = $urandom;
         en = (r[3:0] != 0); master = r[4]; addrless = r[5];
         bd = (r[9:6] == 0); am = (r[12:10] == 0); al = (r[16:13] == 0);
         st = (r[19:17] == 0); sp = (r[22:20] == 0); nk = (r[25:23] == 0);
         rw = r[26]; dw = (r[28:27] == 0); bw = r[29]; bwd = r[30];
         r = $urandom;
         tw = (r[1:0] == 0); twd = r[2]; sr = (r[5:3] == 0);
         step("random");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule